// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that announces each bus cycle on a three-bit, active-low status code. It turns that code into separate active-low strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also drives an address latch strobe and two data transceiver controls: a direction line and an enable.

The status input is asynchronous to the decoder, so it passes through a synchronizer chain of `SYNC_STAGES` flops. A bus cycle begins when the synchronized code leaves the passive value `111`. The decoder latches the code at that point and raises the address latch strobe for one clock. On the next clock it asserts the command that belongs to the latched code. It holds that command until the synchronized status returns to passive.

All outputs are registered. Reset is asserted asynchronously and released through a `RST_STAGES` synchronizer.

Top module: `bus_cmd_decoder`

## Requirements
- R1: The status code is read as a 3-bit value, most significant bit first, and each code drives one command while a cycle is in its command phase. The codes are: `000` interrupt acknowledge (`inta_ack_n_o`), `001` I/O read (`io_rd_n_o`), `010` I/O write (`io_wr_n_o`), `100` and `101` memory read (`mem_rd_n_o`), and `110` memory write (`mem_wr_n_o`). All command outputs are active low.
- R2: When the status code seen at the end of the synchronizer changes from `111` to any other value while no cycle is open, `ale_o` goes high on the next clock edge for exactly one clock.
- R3: The command goes low on the clock edge after the one that raised `ale_o`. It stays low until the synchronized status is `111`, and goes high on the following edge.
- R4: The code `011` (halt) opens a cycle and pulses `ale_o`, but it asserts no command and keeps `xcvr_en_o` low.
- R5: The code is latched when the cycle opens. If the status changes to a different non-passive code during the cycle, the active command does not change.
- R6: `xcvr_dir_tx_o` is 1 (transmit) from the `ale_o` clock until the cycle ends for codes `010` and `110`. In every other case it is 0 (receive).
- R7: `xcvr_en_o` is high exactly while one of the command strobes is low.
- R8: While `rst_n_i` is low, all command strobes are 1 and `ale_o`, `xcvr_dir_tx_o` and `xcvr_en_o` are 0. This takes effect as soon as reset falls, without waiting for a clock.
- R9: At most one command strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bus_stat_n_i | input | 3 | Active-low bus cycle status code |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |
| inta_ack_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| ale_o | output | 1 | Address latch strobe, one clock high |
| xcvr_dir_tx_o | output | 1 | Transceiver direction, 1 = transmit |
| xcvr_en_o | output | 1 | Transceiver enable, active high |

## Verification
The bench builds the decoder with `SYNC_STAGES = 3` and `RST_STAGES = 2`, so that the synchronizer delay is not the default one. Its reference model is written with the same stage count. This parameter set exposes several cases:
- a status blip that lasts one clock still produces a full cycle three clocks later;
- a single passive clock between two cycles lets the next cycle open without a gap;
- an asynchronous reset dropped in the middle of a write is seen at the outputs before the internal reset release completes.

// File: rtl/bscd_pkg.sv
`timescale 1ns/1ps
package bscd_pkg;

  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MEMRD   = 3'b101,
    ST_MEMWR   = 3'b110,
    ST_PASSIVE = 3'b111
  } bus_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic mem_rd_n;
    logic mem_wr_n;
    logic io_rd_n;
    logic io_wr_n;
    logic inta_n;
    logic ale;
    logic dir_tx;
    logic data_en;
  } ctl_s;

  localparam ctl_s CTL_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1, io_rd_n: 1'b1,
                                io_wr_n: 1'b1, inta_n: 1'b1, ale: 1'b0,
                                dir_tx: 1'b0, data_en: 1'b0};

  function automatic logic is_write(bus_stat_e code);
    return (code == ST_IOWR) || (code == ST_MEMWR);
  endfunction

  function automatic ctl_s decode_ctl(phase_e ph, bus_stat_e code);
    ctl_s c;
    c     = CTL_IDLE;
    c.ale = (ph == PH_ADDR);
    if (ph != PH_IDLE) c.dir_tx = is_write(code);
    if (ph == PH_CMD) begin
      case (code)
        ST_INTA:            c.inta_n   = 1'b0;
        ST_IORD:            c.io_rd_n  = 1'b0;
        ST_IOWR:            c.io_wr_n  = 1'b0;
        ST_FETCH, ST_MEMRD: c.mem_rd_n = 1'b0;
        ST_MEMWR:           c.mem_wr_n = 1'b0;
        default:            c.data_en  = 1'b0;
      endcase
      c.data_en = (code != ST_HALT) && (code != ST_PASSIVE);
    end
    return c;
  endfunction

endpackage

// File: rtl/bscd_rst_sync.sv
`timescale 1ns/1ps
module bscd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[LAST];
endmodule

// File: rtl/bscd_stat_sync.sv
`timescale 1ns/1ps
module bscd_stat_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] pipe_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] stage_d;
      if (i == 0) begin : g_head
        assign stage_d = stat_i;
      end else begin : g_tail
        assign stage_d = pipe_q[i-1];
      end
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) pipe_q[i] <= '1;
        else          pipe_q[i] <= stage_d;
      end
    end
  endgenerate

  assign stat_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bscd_phase_fsm.sv
`timescale 1ns/1ps
module bscd_phase_fsm
  import bscd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  bus_stat_e stat_i,
  output phase_e    phase_nxt_o,
  output bus_stat_e code_nxt_o
);
  phase_e    phase_q, phase_nxt;
  bus_stat_e code_q, code_nxt;
  logic      code_ld;

  always_comb begin
    phase_nxt = phase_q;
    code_ld   = 1'b0;
    case (phase_q)
      PH_IDLE: if (stat_i != ST_PASSIVE) begin
        phase_nxt = PH_ADDR;
        code_ld   = 1'b1;
      end
      PH_ADDR: phase_nxt = PH_CMD;
      PH_CMD:  if (stat_i == ST_PASSIVE) phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
    code_nxt = code_ld ? stat_i : code_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) phase_q <= PH_IDLE;
    else          phase_q <= phase_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     code_q <= ST_PASSIVE;
    else if (code_ld) code_q <= code_nxt;
  end

  assign phase_nxt_o = phase_nxt;
  assign code_nxt_o  = code_nxt;

  AST_CMD_ENDS_ON_PASSIVE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_CMD && stat_i == ST_PASSIVE) |=> (phase_q == PH_IDLE)); // R3
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_CMD) |-> $stable(code_q)); // R5
  AST_ADDR_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_ADDR) |=> (phase_q == PH_CMD)); // R2
endmodule

// File: rtl/bscd_ctl_reg.sv
`timescale 1ns/1ps
module bscd_ctl_reg
  import bscd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  phase_e    phase_nxt_i,
  input  bus_stat_e code_nxt_i,
  output ctl_s      ctl_o
);
  ctl_s ctl_q, ctl_d;
  logic [4:0] cmd_low;

  always_comb ctl_d = decode_ctl(phase_nxt_i, code_nxt_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) ctl_q <= CTL_IDLE;
    else          ctl_q <= ctl_d;
  end

  assign ctl_o   = ctl_q;
  assign cmd_low = ~{ctl_q.mem_rd_n, ctl_q.mem_wr_n, ctl_q.io_rd_n,
                     ctl_q.io_wr_n, ctl_q.inta_n};

  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ctl_q.ale |=> !ctl_q.ale); // R2
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(cmd_low)); // R9
  AST_EN_WITH_CMD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ctl_q.data_en == (cmd_low != '0)); // R7
  AST_CMD_AFTER_ALE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(cmd_low != '0) |-> $past(ctl_q.ale)); // R3
  AST_WRITE_TX: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!ctl_q.mem_wr_n || !ctl_q.io_wr_n) |-> ctl_q.dir_tx); // R6
endmodule

// File: rtl/bus_cmd_decoder.sv
`timescale 1ns/1ps
module bus_cmd_decoder
  import bscd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [STAT_W-1:0] bus_stat_n_i,
  output logic              mem_rd_n_o,
  output logic              mem_wr_n_o,
  output logic              io_rd_n_o,
  output logic              io_wr_n_o,
  output logic              inta_ack_n_o,
  output logic              ale_o,
  output logic              xcvr_dir_tx_o,
  output logic              xcvr_en_o
);
  logic              rst_core_n;
  logic [STAT_W-1:0] stat_s;
  phase_e            phase_nxt;
  bus_stat_e         code_nxt;
  ctl_s              ctl;

  bscd_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_core_n));

  bscd_stat_sync #(.STAGES(SYNC_STAGES), .W(STAT_W)) i_stat_sync (
    .clk_i(clk_i), .rst_n_i(rst_core_n), .stat_i(bus_stat_n_i), .stat_o(stat_s));

  bscd_phase_fsm i_fsm (
    .clk_i(clk_i), .rst_n_i(rst_core_n), .stat_i(bus_stat_e'(stat_s)),
    .phase_nxt_o(phase_nxt), .code_nxt_o(code_nxt));

  bscd_ctl_reg i_ctl (
    .clk_i(clk_i), .rst_n_i(rst_core_n), .phase_nxt_i(phase_nxt),
    .code_nxt_i(code_nxt), .ctl_o(ctl));

  assign mem_rd_n_o    = ctl.mem_rd_n;
  assign mem_wr_n_o    = ctl.mem_wr_n;
  assign io_rd_n_o     = ctl.io_rd_n;
  assign io_wr_n_o     = ctl.io_wr_n;
  assign inta_ack_n_o  = ctl.inta_n;
  assign ale_o         = ctl.ale;
  assign xcvr_dir_tx_o = ctl.dir_tx;
  assign xcvr_en_o     = ctl.data_en;
endmodule

// File: tb/test_bus_cmd_decoder.sv
`timescale 1ns/1ps
module test_bus_cmd_decoder;
  localparam int SYNC = 3;
  localparam int RSTS = 2;

  logic       clk;
  logic       rst_n;
  logic [2:0] drv;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, ale, dir_tx, xen;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;
  bit cmp_en = 0;

  bus_cmd_decoder #(.SYNC_STAGES(SYNC), .RST_STAGES(RSTS)) i_bus_cmd_decoder (
    .clk_i(clk), .rst_n_i(rst_n), .bus_stat_n_i(drv),
    .mem_rd_n_o(mem_rd_n), .mem_wr_n_o(mem_wr_n), .io_rd_n_o(io_rd_n),
    .io_wr_n_o(io_wr_n), .inta_ack_n_o(inta_n), .ale_o(ale),
    .xcvr_dir_tx_o(dir_tx), .xcvr_en_o(xen));

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  // Behavioural reference: 0 idle, 1 address, 2 command
  int m_pipe[SYNC];
  int m_ph;
  int m_code;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_code = 7;
      for (int i = 0; i < SYNC; i++) m_pipe[i] = 7;
    end else begin
      int s;
      s = m_pipe[SYNC-1];
      if (m_ph == 0) begin
        if (s != 7) begin m_ph = 1; m_code = s; end
      end else if (m_ph == 1) m_ph = 2;
      else if (s == 7) m_ph = 0;
      for (int i = SYNC-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = int'(drv);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      bit incmd;
      int nlow;
      incmd = (m_ph == 2);
      chk("R1/R3 mem_rd", mem_rd_n, !(incmd && (m_code == 4 || m_code == 5)));
      chk("R1/R3 mem_wr", mem_wr_n, !(incmd && m_code == 6));
      chk("R1/R3 io_rd",  io_rd_n,  !(incmd && m_code == 1));
      chk("R1/R3 io_wr",  io_wr_n,  !(incmd && m_code == 2));
      chk("R1/R3 inta",   inta_n,   !(incmd && m_code == 0));
      chk("R2 ale",       ale,      m_ph == 1);
      chk("R6 dir",       dir_tx,   (m_ph != 0) && (m_code == 2 || m_code == 6));
      chk("R7 en",        xen,      incmd && m_code != 3);
      nlow = 5 - int'(mem_rd_n) - int'(mem_wr_n) - int'(io_rd_n) - int'(io_wr_n) - int'(inta_n);
      chk("R9 one strobe", nlow <= 1, 1'b1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_cycle(logic [2:0] code, int hold, int gap);
    @(negedge clk) drv = code;
    idle(hold);
    drv = 3'b111;
    idle(gap);
  endtask

  initial begin
    rst_n = 1'b0;
    drv   = 3'b111;
    idle(3);
    // R8 reset values
    chk("R8 reset mem_rd", mem_rd_n, 1'b1);
    chk("R8 reset mem_wr", mem_wr_n, 1'b1);
    chk("R8 reset io_rd", io_rd_n, 1'b1);
    chk("R8 reset io_wr", io_wr_n, 1'b1);
    chk("R8 reset inta", inta_n, 1'b1);
    chk("R8 reset ale", ale, 1'b0);
    chk("R8 reset dir", dir_tx, 1'b0);
    chk("R8 reset en", xen, 1'b0);
    rst_n  = 1'b1;
    cmp_en = 1;
    idle(6);

    // R1 every code, several lengths
    bus_cycle(3'b100, 4, 6);
    bus_cycle(3'b101, 5, 6);
    bus_cycle(3'b110, 4, 6);
    bus_cycle(3'b001, 3, 6);
    bus_cycle(3'b010, 6, 6);
    bus_cycle(3'b000, 4, 6);

    // R4 halt: ale pulse only
    @(negedge clk) drv = 3'b011;
    idle(SYNC + 3);
    chk("R4 halt mem_rd", mem_rd_n, 1'b1);
    chk("R4 halt io_rd", io_rd_n, 1'b1);
    chk("R4 halt inta", inta_n, 1'b1);
    chk("R4 halt en", xen, 1'b0);
    drv = 3'b111;
    idle(6);

    // R5 code change mid-cycle is ignored
    @(negedge clk) drv = 3'b001;
    idle(SYNC + 3);
    drv = 3'b110;
    idle(SYNC + 2);
    chk("R5 io_rd held", io_rd_n, 1'b0);
    chk("R5 mem_wr not taken", mem_wr_n, 1'b1);
    chk("R6 dir stays receive", dir_tx, 1'b0);
    drv = 3'b111;
    idle(6);

    // R2/R3 one-clock blip and back-to-back cycles with one passive clock
    bus_cycle(3'b101, 1, 6);
    bus_cycle(3'b110, 3, 1);
    bus_cycle(3'b001, 3, 1);
    bus_cycle(3'b000, 2, 8);

    // R8 asynchronous reset during a write command
    @(negedge clk) drv = 3'b110;
    idle(SYNC + 3);
    chk("R1 mem_wr before reset", mem_wr_n, 1'b0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R8 async mem_wr", mem_wr_n, 1'b1);
    chk("R8 async en", xen, 1'b0);
    chk("R8 async dir", dir_tx, 1'b0);
    drv = 3'b111;
    idle(2);
    rst_n = 1'b1;
    idle(6);
    bus_cycle(3'b100, 3, 6);

    finish_run();
  end
endmodule